// File: doc/BRIEF.md
# DRAM Auto Access Sequencer

This block turns a single falling edge on an access strobe into the full strobe sequence for one multiplexed DRAM access. A parallel address, which holds a row field, a column field and a bank field, passes through a set of transparent latches while the address-open input is high. The latches hold that address once the input goes low. When the access strobe falls in one of the two automatic modes, the row strobe of the decoded bank goes low with the row address on the multiplexed outputs. After a row-hold interval the outputs switch to the column address. One column-setup interval later the column strobe goes low.

Clock-cycle counters provide the hold and setup intervals, so no separate timing clock is needed. The slow automatic mode uses a longer row hold than the fast one. If chip select is inactive when the strobe falls, the block runs a hidden refresh instead: it places the refresh address on the outputs and drives all four row strobes low. The write-enable output is a plain buffered copy of its input.

Top module: `dram_auto_seq`

## Requirements
- R1: While `addr_open` is 1 the address latches are transparent, and `ma` shows `row_in` in the same cycle. On the rising clock edges where `addr_open` is 0 the latches keep the value captured at the last edge where it was 1, whatever the inputs do.
- R2: During an access exactly one bit of `ras_n` is low, and its index equals the bank field (bank value b drives `ras_n[b]` low).
- R3: If `access_n` was 1 at one rising edge and is 0 at the next, with `mode` 5 or 6 and `cs_n` 0, the selected row strobe is low after that edge while `ma` carries the row address.
- R4: `ma` switches from row to column after the row hold. Mode 6 (fast) uses 1 clock cycle and mode 5 (slow) uses 2 cycles, both counted from the edge that asserted the row strobe.
- R5: `cas_n` goes low one clock cycle (the column setup) after `ma` switches to the column address.
- R6: At the first rising edge that samples `access_n` high, all row strobes and `cas_n` return high and `ma` returns to the row address, all after that same edge.
- R7: `we_n` equals `wr_n_in` at all times and is not affected by the sequence.
- R8: If `cs_n` is 1 when the falling strobe is sampled in mode 5 or 6, all four `ras_n` bits go low, `ma` shows `ref_addr`, and `cas_n` stays high until the strobe rises.
- R9: In any mode other than 5 or 6 a falling access strobe is ignored. `ras_n` stays 4'b1111 and `cas_n` stays 1.
- R10: After reset, with `addr_open` 0, `ras_n` is 4'b1111, `cas_n` is 1 and `ma` is 0.
- R11: If the strobe rises before the column strobe would have asserted, the access aborts and `cas_n` never goes low for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_open | input | 1 | High: address latches transparent; low: hold |
| row_in | input | 9 | Row address field |
| col_in | input | 9 | Column address field |
| bank_in | input | 2 | Bank select field |
| access_n | input | 1 | Active-low access strobe |
| cs_n | input | 1 | Active-low chip select |
| mode | input | 3 | Operating mode; 5 = slow auto, 6 = fast auto |
| wr_n_in | input | 1 | External write control |
| ref_addr | input | 9 | Refresh row address |
| ma | output | 9 | Multiplexed DRAM address |
| ras_n | output | 4 | Active-low row strobes, one per bank |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Buffered write enable |

## Verification
A wrong sequencer phase or hold count shows at the ports within one or two cycles of the strobe edge. It appears as a column address or column strobe one cycle early or late against the mode's hold. A wrongly captured bank shows at once as the wrong row strobe in the first cycle after the fall. A missed release shows as strobes still low one cycle after the strobe rises. Latch faults show as a wrong row address on `ma` before any access begins.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROWH,
    PH_COLS,
    PH_CASA,
    PH_REF
  } phase_t;

  localparam logic [2:0] MODE_SLOW = 3'd5;
  localparam logic [2:0] MODE_FAST = 3'd6;

  function automatic logic is_auto(input logic [2:0] m);
    return (m == MODE_SLOW) || (m == MODE_FAST);
  endfunction

  function automatic int unsigned hold_for(input logic [2:0] m,
                                           input int unsigned slow,
                                           input int unsigned fast);
    return (m == MODE_SLOW) ? slow : fast;
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned t;
    t = (a > b) ? a : b;
    return (t > c) ? t : c;
  endfunction
endpackage

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)      held <= '0;
    else if (open_i) held <= d_i;
  end

  assign q_o = open_i ? d_i : held;

  // R1: a closed latch keeps its output while the input moves
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_i && $past(!open_i) && $past(rst_n)) |-> $stable(q_o));
endmodule

// File: rtl/access_timer.sv
module access_timer
  import dram_seq_pkg::*;
#(
  parameter int unsigned HOLD_SLOW = 2,
  parameter int unsigned HOLD_FAST = 1,
  parameter int unsigned SETUP     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_n,
  input  logic       cs_n,
  input  logic [2:0] mode,
  output phase_t     phase,
  output logic       col_sel,
  output logic       fall_evt
);
  localparam int unsigned MAXC = max3(HOLD_SLOW, HOLD_FAST, SETUP);
  localparam int CW = $clog2(MAXC + 1);

  logic          prev_hi;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hold_load;
  logic          start_acc;
  logic          start_ref;

  assign fall_evt  = prev_hi && !acc_n && (phase == PH_IDLE);
  assign hold_load = CW'(hold_for(mode, HOLD_SLOW, HOLD_FAST) - 1);
  assign start_acc = fall_evt && is_auto(mode) && !cs_n;
  assign start_ref = fall_evt && is_auto(mode) && cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      prev_hi <= 1'b1;
    end else begin
      prev_hi <= acc_n;
      if (acc_n) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            if (start_ref) phase <= PH_REF;
            else if (start_acc) begin
              phase <= PH_ROWH;
              cnt   <= hold_load;
            end
          end
          PH_ROWH: begin
            if (cnt == '0) begin
              phase <= PH_COLS;
              cnt   <= CW'(SETUP - 1);
            end else cnt <= cnt - 1'b1;
          end
          PH_COLS: begin
            if (cnt == '0) phase <= PH_CASA;
            else cnt <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign col_sel = (phase == PH_COLS) || (phase == PH_CASA);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (phase == PH_ROWH));
  p_ref_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ref |=> (phase == PH_REF));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !is_auto(mode)) |=> (phase == PH_IDLE));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_n |=> (phase == PH_IDLE));
  p_col_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_sel) |-> ($past(phase) == PH_ROWH));
endmodule

// File: rtl/strobe_out.sv
module strobe_out
  import dram_seq_pkg::*;
#(
  parameter int AW    = 9,
  parameter int BANKS = 4,
  localparam int BW   = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic          col_sel,
  input  logic          fall_evt,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] row_i,
  input  logic [AW-1:0] col_i,
  input  logic [AW-1:0] ref_i,
  output logic [AW-1:0] ma,
  output logic [BANKS-1:0] ras_n,
  output logic          cas_n
);
  logic [BW-1:0] bank_q;
  logic          acc_on;
  logic          ref_on;

  always_ff @(posedge clk) begin
    if (!rst_n)        bank_q <= '0;
    else if (fall_evt) bank_q <= bank_i;
  end

  assign acc_on = (phase == PH_ROWH) || (phase == PH_COLS) || (phase == PH_CASA);
  assign ref_on = (phase == PH_REF);

  for (genvar i = 0; i < BANKS; i++) begin : g_ras
    assign ras_n[i] = !((acc_on && (bank_q == BW'(i))) || ref_on);
  end

  assign cas_n = !(phase == PH_CASA);
  assign ma    = ref_on ? ref_i : (col_sel ? col_i : row_i);

  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_on |-> ($countones(~ras_n) == 1));
  p_cas_on_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (col_sel && $past(col_sel)));
  p_ref_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_on |-> ((ras_n == '0) && cas_n));
endmodule

// File: rtl/dram_auto_seq.sv
module dram_auto_seq
  import dram_seq_pkg::*;
#(
  parameter int AW              = 9,
  parameter int BANKS           = 4,
  parameter int unsigned HOLD_SLOW = 2,
  parameter int unsigned HOLD_FAST = 1,
  parameter int unsigned SETUP     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_open,
  input  logic [8:0]       row_in,
  input  logic [8:0]       col_in,
  input  logic [1:0]       bank_in,
  input  logic             access_n,
  input  logic             cs_n,
  input  logic [2:0]       mode,
  input  logic             wr_n_in,
  input  logic [8:0]       ref_addr,
  output logic [8:0]       ma,
  output logic [3:0]       ras_n,
  output logic             cas_n,
  output logic             we_n
);
  localparam int BW = $clog2(BANKS);
  localparam int LW = 2 * AW + BW;

  logic [LW-1:0] lat_q;
  logic [AW-1:0] row_eff, col_eff;
  logic [BW-1:0] bank_eff;
  phase_t        phase;
  logic          col_sel;
  logic          fall_evt;

  addr_latch #(.W(LW)) u_latch (
    .clk(clk), .rst_n(rst_n), .open_i(addr_open),
    .d_i({bank_in, col_in, row_in}), .q_o(lat_q)
  );

  assign row_eff  = lat_q[AW-1:0];
  assign col_eff  = lat_q[2*AW-1:AW];
  assign bank_eff = lat_q[LW-1:2*AW];

  access_timer #(.HOLD_SLOW(HOLD_SLOW), .HOLD_FAST(HOLD_FAST), .SETUP(SETUP)) u_timer (
    .clk(clk), .rst_n(rst_n), .acc_n(access_n), .cs_n(cs_n), .mode(mode),
    .phase(phase), .col_sel(col_sel), .fall_evt(fall_evt)
  );

  strobe_out #(.AW(AW), .BANKS(BANKS)) u_out (
    .clk(clk), .rst_n(rst_n), .phase(phase), .col_sel(col_sel),
    .fall_evt(fall_evt), .bank_i(bank_eff), .row_i(row_eff), .col_i(col_eff),
    .ref_i(ref_addr), .ma(ma), .ras_n(ras_n), .cas_n(cas_n)
  );

  assign we_n = wr_n_in;

  p_rise_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    access_n |=> ((ras_n == 4'hF) && cas_n));
endmodule

// File: tb/dram_auto_seq_test.sv
`timescale 1ns/1ps
module dram_auto_seq_test;
  logic clk = 0, rst_n = 0;
  logic addr_open = 0, access_n = 1, cs_n = 0, wr_n_in = 1;
  logic [8:0] row_in = 0, col_in = 0, ref_addr = 9'h0C3;
  logic [1:0] bank_in = 0;
  logic [2:0] mode = 3'd6;
  logic [8:0] ma;
  logic [3:0] ras_n;
  logic cas_n, we_n;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  dram_auto_seq uut (.*);

  // vector: {mode[3], cs_n[1], bank[2], row[9], col[9]}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {3'd6, 1'b0, 2'd0, 9'h155, 9'h0AA},
    {3'd6, 1'b0, 2'd1, 9'h001, 9'h1FE},
    {3'd6, 1'b0, 2'd3, 9'h1F0, 9'h00F},
    {3'd5, 1'b0, 2'd2, 9'h123, 9'h0DE},
    {3'd5, 1'b0, 2'd3, 9'h080, 9'h101},
    {3'd5, 1'b1, 2'd1, 9'h044, 9'h0BB},
    {3'd4, 1'b0, 2'd2, 9'h0F0, 9'h10F}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_addr(logic [8:0] r, logic [8:0] c, logic [1:0] b);
    @(negedge clk);
    addr_open = 1; row_in = r; col_in = c; bank_in = b;
    @(negedge clk);
    addr_open = 0; row_in = ~r; col_in = ~c; bank_in = ~b;
  endtask

  task automatic run_vec(logic [23:0] v);
    logic [2:0] m; logic cs; logic [1:0] b; logic [8:0] r, c;
    int h;
    logic automode;
    {m, cs, b, r, c} = v;
    automode = (m == 3'd5) || (m == 3'd6);
    h = (m == 3'd5) ? 2 : 1;
    load_addr(r, c, b);
    mode = m; cs_n = cs;
    check("R1 held row", ma, r);
    access_n = 0;
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      if (!automode) begin
        check("R9 ras", ras_n, 4'hF);
        check("R9 cas", cas_n, 1);
      end else if (cs) begin
        check("R8 ras", ras_n, 4'h0);
        check("R8 ma", ma, ref_addr);
        check("R8 cas", cas_n, 1);
      end else begin
        check("R2/R3 ras", ras_n, ~(4'b1 << b) & 4'hF);
        check("R4 ma", ma, (j > h) ? c : r);
        check("R5 cas", cas_n, (j > h + 1) ? 1'b0 : 1'b1);
      end
    end
    access_n = 1;
    @(negedge clk);
    check("R6 ras", ras_n, 4'hF);
    check("R6 cas", cas_n, 1);
    check("R6 ma", ma, r);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 ras", ras_n, 4'hF);
    check("R10 cas", cas_n, 1);
    check("R10 ma", ma, 9'h0);

    // R1 transparency
    addr_open = 1; row_in = 9'h1A5;
    #1 check("R1 pass", ma, 9'h1A5);

    // R7 write-enable buffer
    wr_n_in = 0; #1 check("R7 we low", we_n, 0);
    wr_n_in = 1; #1 check("R7 we high", we_n, 1);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R11: slow mode, strobe rises after two cycles, before column strobe
    load_addr(9'h0AB, 9'h1CD, 2'd1);
    mode = 3'd5; cs_n = 0; access_n = 0;
    repeat (2) begin
      @(negedge clk);
      check("R11 cas during", cas_n, 1);
    end
    access_n = 1;
    repeat (3) begin
      @(negedge clk);
      check("R11 cas after", cas_n, 1);
      check("R11 ras after", ras_n, 4'hF);
    end

    // R7 during an access
    load_addr(9'h011, 9'h022, 2'd0);
    mode = 3'd6; access_n = 0;
    @(negedge clk);
    wr_n_in = 0; #1 check("R7 we in access", we_n, 0);
    wr_n_in = 1; access_n = 1;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule